// File: doc/BRIEF.md
# Period Timer with Input Capture

A 16-bit up-counter that runs from zero up to a programmable 16-bit period value, then returns to zero and raises a sticky timer flag. It advances on count steps. A step comes either from an internal tick, which is one clock in every `TICK_DIV`, or from rising edges of an external count input. A run bit gates the steps.

Beside the counter sits one input-capture channel. An asynchronous capture input is synchronized, and an edge/prescale selector turns it into capture events. Each event copies the counter into a capture register, provided the previous captured value has already been read. If it has not been read, the event is recorded in a hidden overflow bit. That bit becomes visible only after software has read both capture bytes.

A byte-wide register port gives access to the period, the control, the flags and the capture value. Two interrupt outputs are formed from the flags and their enable bits.

Top module: `cap_timer`

## Requirements
- R1: Register map on `reg_addr`:
  - 0: period low byte (read/write).
  - 1: period high byte (read/write).
  - 2: capture low byte (read).
  - 3: capture high byte (read).
  - 4: control (read/write). Bit 0 is run, bit 1 selects the source (1 = external), bits 3:2 are the edge select, bit 4 is the timer interrupt enable, bit 5 is the capture interrupt enable.
  - 5: status. Bit 0 is the timer flag, bit 1 the capture flag, bit 2 the visible overflow. Writing 1 to bit 0 or bit 1 clears that flag.
  - 6: counter low byte (read).
  - 7: counter high byte (read).
  - After reset every register reads 0.
- R2: On a count step with the counter equal to the period, the counter becomes 0000h and the timer flag is set. On any other step it increments by one.
- R3: A period of 0000h holds the counter at zero and sets the timer flag on every count step.
- R4: With run clear the counter does not change. With source = 1, each synchronized rising edge of `ext_clk_in` is one step. With source = 0, a step occurs once every `TICK_DIV` clocks.
- R5: Both flags stay set until cleared through the status register. A set in the same cycle as a clear wins. `tmr_irq` is the timer flag AND its enable, and `cap_irq` is the capture flag AND its enable.
- R6: Edge select 00 makes every falling edge of the synchronized `cap_in` an event, and 01 makes every rising edge an event.
- R7: Edge select 10 makes every 4th rising edge an event, and 11 makes every 16th rising edge an event. Both count rising edges with one 4-bit prescaler.
- R8: An event with no unread capture copies the counter into the capture register, sets the capture flag and marks the value unread.
- R9: An event while a value is unread leaves the capture register and the capture flag unchanged, and sets a hidden overflow bit.
- R10: Once both capture bytes have been read, in either order, the hidden overflow bit is copied to status bit 2, the hidden bit is cleared and the value counts as read. A read that completes this in the same cycle as an event is applied first.
- R11: A change of the edge select does not clear the prescaler. Only reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ext_clk_in | input | 1 | Asynchronous external count input |
| cap_in | input | 1 | Asynchronous capture input |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (marks capture byte reads) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| tmr_irq | output | 1 | Timer interrupt |
| cap_irq | output | 1 | Capture interrupt |

## Verification
The assertions take for granted that `ext_clk_in` and `cap_in` hold each level for at least two clocks, so that the synchronizer sees every edge. They also assume that `reg_rd` and `reg_wr` are never raised together. The stimulus holds both asynchronous inputs for four clocks per level. It drives one register strobe at a time, at the falling clock edge. Capture values are made deterministic by counting known external pulses and then stopping the counter before capturing.

// File: rtl/cap_timer.sv
module cap_timer #(
  parameter int TICK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_clk_in,
  input  logic       cap_in,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       tmr_irq,
  output logic       cap_irq
);
  localparam int TW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;

  logic [15:0] per_q, cnt_q, cap_q;
  logic        run_q, src_q, tie_q, cie_q;
  logic [1:0]  sel_q;
  logic        tmr_f, cap_f, unread, lo_seen, hi_seen, mst_ovf, vis_ovf;
  logic [2:0]  esync, csync;
  logic [3:0]  psc;
  logic [TW-1:0] div;

  wire tick     = (div == TW'(TICK_DIV - 1));
  wire ext_rise = esync[1] & ~esync[2];
  wire step     = run_q & (src_q ? ext_rise : tick);
  wire wrap     = step & (cnt_q == per_q);
  wire c_rise   = csync[1] & ~csync[2];
  wire c_fall   = ~csync[1] & csync[2];

  logic cap_evt;
  always_comb begin
    case (sel_q)
      2'b00:   cap_evt = c_fall;
      2'b01:   cap_evt = c_rise;
      2'b10:   cap_evt = c_rise & (psc[1:0] == 2'b11);
      default: cap_evt = c_rise & (psc == 4'hF);
    endcase
  end

  wire wr_sel     = reg_wr;
  wire rd_lo      = reg_rd & (reg_addr == 3'd2);
  wire rd_hi      = reg_rd & (reg_addr == 3'd3);
  wire both_done  = (lo_seen | rd_lo) & (hi_seen | rd_hi);
  wire unread_eff = unread & ~both_done;
  wire latch      = cap_evt & ~unread_eff;
  wire stat_wr    = wr_sel & (reg_addr == 3'd5);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div   <= '0;
      esync <= '0;
      csync <= '0;
      psc   <= '0;
    end else begin
      div   <= tick ? '0 : div + 1'b1;
      esync <= {esync[1:0], ext_clk_in};
      csync <= {csync[1:0], cap_in};
      if (c_rise) psc <= psc + 4'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= '0;
      run_q <= 1'b0;
      src_q <= 1'b0;
      sel_q <= 2'b00;
      tie_q <= 1'b0;
      cie_q <= 1'b0;
    end else if (wr_sel) begin
      case (reg_addr)
        3'd0: per_q[7:0]  <= reg_wdata;
        3'd1: per_q[15:8] <= reg_wdata;
        3'd4: {cie_q, tie_q, sel_q, src_q, run_q} <= reg_wdata[5:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tmr_f <= 1'b0;
    end else begin
      if (step) cnt_q <= wrap ? 16'h0000 : cnt_q + 16'd1;
      if (wrap) tmr_f <= 1'b1;
      else if (stat_wr && reg_wdata[0]) tmr_f <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q   <= '0;
      cap_f   <= 1'b0;
      unread  <= 1'b0;
      lo_seen <= 1'b0;
      hi_seen <= 1'b0;
      mst_ovf <= 1'b0;
      vis_ovf <= 1'b0;
    end else begin
      if (both_done) begin
        vis_ovf <= mst_ovf;
        mst_ovf <= 1'b0;
        unread  <= 1'b0;
        lo_seen <= 1'b0;
        hi_seen <= 1'b0;
      end else begin
        if (rd_lo) lo_seen <= 1'b1;
        if (rd_hi) hi_seen <= 1'b1;
      end
      if (cap_evt) begin
        if (unread_eff) begin
          mst_ovf <= 1'b1;
        end else begin
          cap_q   <= cnt_q;
          unread  <= 1'b1;
          lo_seen <= 1'b0;
          hi_seen <= 1'b0;
        end
      end
      if (latch) cap_f <= 1'b1;
      else if (stat_wr && reg_wdata[1]) cap_f <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0: reg_rdata = per_q[7:0];
      3'd1: reg_rdata = per_q[15:8];
      3'd2: reg_rdata = cap_q[7:0];
      3'd3: reg_rdata = cap_q[15:8];
      3'd4: reg_rdata = {2'b00, cie_q, tie_q, sel_q, src_q, run_q};
      3'd5: reg_rdata = {5'b00000, vis_ovf, cap_f, tmr_f};
      3'd6: reg_rdata = cnt_q[7:0];
      default: reg_rdata = cnt_q[15:8];
    endcase
  end

  assign tmr_irq = tmr_f & tie_q;
  assign cap_irq = cap_f & cie_q;

  a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == 16'h0000) && tmr_f);
  a_r4_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt_q));
  a_r8_latch_counter: assert property (@(posedge clk) disable iff (!rst_n)
    latch |=> cap_f && unread && (cap_q == $past(cnt_q)));
  a_r9_protect_unread: assert property (@(posedge clk) disable iff (!rst_n)
    (unread && !both_done) |=> $stable(cap_q));
  a_r10_master_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (both_done && !cap_evt) |=> !mst_ovf && !unread);
  a_r11_prescaler_advance: assert property (@(posedge clk) disable iff (!rst_n)
    c_rise |=> psc == $past(psc) + 4'd1);
endmodule

// File: tb/tb_cap_timer.sv
module tb_cap_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_clk_in = 1'b0, cap_in = 1'b0;
  logic [2:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic tmr_irq, cap_irq;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  cap_timer dut (.clk(clk), .rst_n(rst_n), .ext_clk_in(ext_clk_in), .cap_in(cap_in),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tmr_irq(tmr_irq), .cap_irq(cap_irq));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ext_clk_in = 1'b0; cap_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
  endtask

  task automatic ext_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      ext_clk_in = 1'b1; repeat (4) @(negedge clk);
      ext_clk_in = 1'b0; repeat (4) @(negedge clk);
    end
  endtask

  task automatic cap_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      cap_in = 1'b1; repeat (4) @(negedge clk);
      cap_in = 1'b0; repeat (4) @(negedge clk);
    end
  endtask

  task automatic set_count(input int n, input logic [1:0] sel);
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF);
    wr(3'd4, {4'b0000, sel, 2'b11});
    ext_pulses(n);
    wr(3'd4, {4'b0000, sel, 2'b10});
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 8; a++) begin
      peek(3'(a), d);
      chk($sformatf("R1 reset reg %0d", a), d, 0);
    end
    chk("R5 reset tmr_irq", tmr_irq, 0);
    chk("R5 reset cap_irq", cap_irq, 0);
  endtask

  task automatic t_wrap();
    logic [7:0] d;
    do_reset();
    wr(3'd0, 8'h05); wr(3'd4, 8'h03);
    ext_pulses(5);
    peek(3'd6, d); chk("R2 count to period", d, 5);
    peek(3'd5, d); chk("R2 no flag before wrap", d[0], 0);
    ext_pulses(1);
    peek(3'd6, d); chk("R2 wrap to zero", d, 0);
    peek(3'd5, d); chk("R2 flag on wrap", d[0], 1);
    chk("R5 irq masked", tmr_irq, 0);
    wr(3'd4, 8'h13);
    chk("R5 irq enabled", tmr_irq, 1);
    ext_pulses(2);
    peek(3'd5, d); chk("R5 flag sticky", d[0], 1);
    wr(3'd5, 8'h01);
    peek(3'd5, d); chk("R5 flag cleared", d[0], 0);
    chk("R5 irq cleared", tmr_irq, 0);
  endtask

  task automatic t_run_gate();
    logic [7:0] d;
    do_reset();
    wr(3'd0, 8'h40); wr(3'd4, 8'h03);
    ext_pulses(3);
    wr(3'd4, 8'h02);
    ext_pulses(3);
    peek(3'd6, d); chk("R4 run clear holds count", d, 3);
  endtask

  task automatic t_period_zero();
    logic [7:0] d;
    do_reset();
    wr(3'd4, 8'h03);
    ext_pulses(2);
    peek(3'd6, d); chk("R3 zero period holds", d, 0);
    peek(3'd5, d); chk("R3 flag with zero period", d[0], 1);
    wr(3'd5, 8'h01);
    ext_pulses(1);
    peek(3'd5, d); chk("R3 flag every step", d[0], 1);
  endtask

  task automatic t_internal();
    logic [7:0] d;
    do_reset();
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF);
    wr(3'd4, 8'h01);
    repeat (39) @(negedge clk);
    wr(3'd4, 8'h00);
    peek(3'd6, d);
    chk("R4 internal tick rate", int'(d >= 9 && d <= 11), 1);
  endtask

  task automatic t_rise();
    logic [7:0] d;
    do_reset();
    set_count(7, 2'b01);
    cap_pulses(1);
    peek(3'd5, d); chk("R8 capture flag", d[1], 1);
    rd(3'd2, d); chk("R8 capture low", d, 7);
    rd(3'd3, d); chk("R8 capture high", d, 0);
    wr(3'd4, 8'h26);
    chk("R5 cap irq enabled", cap_irq, 1);
    wr(3'd5, 8'h02);
    chk("R5 cap irq cleared", cap_irq, 0);
  endtask

  task automatic t_fall();
    logic [7:0] d;
    do_reset();
    set_count(3, 2'b00);
    cap_in = 1'b1; repeat (4) @(negedge clk);
    peek(3'd5, d); chk("R6 rising ignored in falling mode", d[1], 0);
    cap_in = 1'b0; repeat (4) @(negedge clk);
    peek(3'd5, d); chk("R6 falling edge event", d[1], 1);
    peek(3'd2, d); chk("R6 falling capture value", d, 3);
  endtask

  task automatic t_overflow();
    logic [7:0] d;
    do_reset();
    set_count(2, 2'b01);
    cap_pulses(1);
    wr(3'd5, 8'h02);
    wr(3'd4, 8'h07); ext_pulses(2); wr(3'd4, 8'h06);
    cap_pulses(1);
    peek(3'd5, d); chk("R9 no flag on overflow event", d[1], 0);
    rd(3'd2, d); chk("R9 earlier value kept", d, 2);
    peek(3'd5, d); chk("R10 overflow hidden after one read", d[2], 0);
    rd(3'd3, d);
    peek(3'd5, d); chk("R10 overflow visible after both", d[2], 1);
    cap_pulses(1);
    rd(3'd3, d);
    rd(3'd2, d); chk("R8 new capture after read", d, 4);
    peek(3'd5, d); chk("R10 reverse order clears visible", d[2], 0);
  endtask

  task automatic t_prescale();
    logic [7:0] d;
    do_reset();
    set_count(1, 2'b10);
    cap_pulses(3);
    peek(3'd5, d); chk("R7 no event before 4th", d[1], 0);
    cap_pulses(1);
    peek(3'd5, d); chk("R7 event on 4th", d[1], 1);
    rd(3'd2, d); rd(3'd3, d); wr(3'd5, 8'h02);
    wr(3'd4, 8'h0E);
    cap_pulses(11);
    peek(3'd5, d); chk("R7 no event before 16th", d[1], 0);
    cap_pulses(1);
    peek(3'd5, d); chk("R7 event on 16th", d[1], 1);
  endtask

  task automatic t_no_psc_reset();
    logic [7:0] d;
    do_reset();
    wr(3'd4, 8'h0C);
    cap_pulses(3);
    wr(3'd4, 8'h08);
    cap_pulses(1);
    peek(3'd5, d); chk("R11 prescaler kept over select change", d[1], 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wrap();
    t_run_gate();
    t_period_zero();
    t_internal();
    t_rise();
    t_fall();
    t_overflow();
    t_prescale();
    t_no_psc_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule